// File: doc/BRIEF.md
# SPI Master/Slave Port Controller

This block is a synchronous serial port that can act as the clock-driving master or as a clock-following slave on an SPI bus. Software reaches it through a small register interface of three addresses: a four-bit control word, a 16-bit data window and a read-only status word. Writing the data window queues a word for sending. Reading it takes the oldest word received. Each of the two directions has its own FIFO.

As master, the port produces SCLK in mode 0 and lowers SSEL around each frame. It shifts its word out on MOSI, most significant bit first, and captures MISO. As slave, it passes the three incoming lines through a synchronizer. It loads its next word when SSEL falls and shifts it out on MISO while it captures MOSI. Each pin has an output enable that follows the control word. This lets the chip share the bus lines. A loopback bit feeds the port's own serial output back into its receiver. The frame length is a static parameter from 4 to 16 bits.

Top module: `spi_port_ctl`

## Requirements
- R1: After reset the control word reads 0 and the status word reads 1 (transmit space available, nothing received, idle). All four output enables are 0 and ssel_n_o is 1.
- R2: The control word is at address 0: bit 3 slave-output-off, bit 2 role (0 master, 1 slave), bit 1 enable, bit 0 loopback. A write stores these four bits and a read of address 0 returns them.
- R3: A control write changes the role bit only if enable was 0 before the write. A single write that sets role and enable together while the port is disabled takes both. Other bits can be written at any time.
- R4: While the port is enabled as master, sclk_oe, mosi_oe and ssel_oe are 1 and miso_oe is 0. While it is enabled as slave, miso_oe equals the inverse of slave-output-off and the other three are 0. While it is disabled, all four are 0. Slave-output-off has no effect in master mode.
- R5: While the port is disabled, no frame starts. sclk_o stays 0 and ssel_n_o stays 1, but data writes still queue.
- R6: A master frame lowers ssel_n_o and sends FRAME_W bits in mode 0, most significant bit first. The receiver captures miso_i on each rising SCLK edge.
- R7: With loopback set, the receiver takes the port's own serial output (MOSI as master, MISO as slave), and the input pin has no effect.
- R8: The transmit FIFO holds 8 words. A data write (address 1) to a full FIFO is dropped, and status bit 0 is 0 while the FIFO is full.
- R9: A read of address 1 pops the oldest received word, right-justified with zeros above the frame. When nothing is queued, the read returns 0 and has no effect. Status bit 1 is 1 while the receive FIFO is not empty.
- R10: Status bit 2 (busy) is 1 while a frame is in progress or the transmit FIFO is not empty.
- R11: A slave frame begins when SSEL falls. The slave sends its next queued word on MISO (all zeros if none is queued), captures MOSI, and pushes one received word per frame.
- R12: Words queued back to back go out in write order, one frame each, and give exactly one received word per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at address 1) |
| reg_addr | input | 2 | 0 control, 1 data, 2 status |
| reg_wdata | input | 16 | Write data, right-justified |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_oe | output | 1 | Output enable for sclk_o |
| sclk_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Output enable for mosi_o |
| mosi_i | input | 1 | Master data in (slave) |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Output enable for miso_o |
| miso_i | input | 1 | Slave data in (master) |
| ssel_n_o | output | 1 | Active-low select out (master) |
| ssel_oe | output | 1 | Output enable for ssel_n_o |
| ssel_n_i | input | 1 | Active-low select in (slave) |

## Verification
The hardest situation to reach from the pins is the role lock. A control write must try to flip the role bit at the moment enable is already set, and must then be followed by the legal combined write from the disabled state. The bench writes these sequences in turn and checks the control readback after each one. Its behavioural control model, compared with the four output enables on every clock, catches any cycle in which the role changes when it should not. The full-FIFO drop is reached by queuing nine words while the port is disabled and then enabling loopback, so the receive side shows exactly which words were sent. The slave role is driven by a bench master with a slow SCLK, which leaves room for the synchronizer latency.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_DATA = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;

   typedef struct packed {
      logic sod;   // bit 3: slave drives no MISO
      logic ms;    // bit 2: 1 = slave role
      logic en;    // bit 1: port enable
      logic lb;    // bit 0: internal loopback
   } ctrl_t;

   typedef enum logic [1:0] {
      M_IDLE  = 2'd0,
      M_SHIFT = 2'd1,
      M_DONE  = 2'd2,
      M_GAP   = 2'd3
   } mst_state_t;

endpackage

// File: rtl/spi_port_fifo.sv
module spi_port_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int AW = $clog2(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [AW:0]      fill;
   logic             do_push, do_pop;

   assign full    = (fill == (AW+1)'(DEPTH));
   assign empty   = (fill == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         fill <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= (AW+1)'(DEPTH));

   assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);

endmodule

// File: rtl/spi_port_master.sv
module spi_port_master
   import spi_port_pkg::*;
#(
   parameter int FRAME_W  = 8,
   parameter int CLK_HALF = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               lb,
   input  logic               tx_valid,
   input  logic [FRAME_W-1:0] tx_word,
   output logic               tx_pop,
   input  logic               miso_i,
   output logic               sclk_o,
   output logic               mosi_o,
   output logic               ssel_n_o,
   output logic               rx_push,
   output logic [FRAME_W-1:0] rx_word,
   output logic               active
);
   localparam int CW = $clog2(FRAME_W);
   localparam int PW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

   mst_state_t         st;
   logic [FRAME_W-1:0] tx_sh, rx_sh;
   logic [CW-1:0]      bit_cnt;
   logic [PW-1:0]      ph;
   logic               in_bit, ph_end;

   assign in_bit   = lb ? tx_sh[FRAME_W-1] : miso_i;
   assign ph_end   = (ph == PW'(CLK_HALF - 1));
   assign mosi_o   = tx_sh[FRAME_W-1];
   assign tx_pop   = run && (st == M_IDLE) && tx_valid;
   assign rx_push  = (st == M_DONE);
   assign rx_word  = rx_sh;
   assign active   = (st != M_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= M_IDLE;
         tx_sh    <= '0;
         rx_sh    <= '0;
         bit_cnt  <= '0;
         ph       <= '0;
         sclk_o   <= 1'b0;
         ssel_n_o <= 1'b1;
      end else if (!run) begin
         st       <= M_IDLE;
         ph       <= '0;
         bit_cnt  <= '0;
         sclk_o   <= 1'b0;
         ssel_n_o <= 1'b1;
      end else begin
         case (st)
            M_IDLE: if (tx_valid) begin
               tx_sh    <= tx_word;
               ssel_n_o <= 1'b0;
               ph       <= '0;
               bit_cnt  <= '0;
               st       <= M_SHIFT;
            end
            M_SHIFT: if (ph_end) begin
               ph <= '0;
               if (!sclk_o) begin
                  sclk_o <= 1'b1;
                  rx_sh  <= {rx_sh[FRAME_W-2:0], in_bit};
               end else begin
                  sclk_o <= 1'b0;
                  if (bit_cnt == CW'(FRAME_W - 1)) begin
                     st <= M_DONE;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                     tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
                  end
               end
            end else begin
               ph <= ph + 1'b1;
            end
            M_DONE: begin
               ssel_n_o <= 1'b1;
               ph       <= '0;
               st       <= M_GAP;
            end
            default: if (ph_end) begin
               ph <= '0;
               st <= M_IDLE;
            end else begin
               ph <= ph + 1'b1;
            end
         endcase
      end
   end

   assert_sclk_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |-> !ssel_n_o);

   assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

endmodule

// File: rtl/spi_port_slave.sv
module spi_port_slave #(
   parameter int FRAME_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               lb,
   input  logic               tx_valid,
   input  logic [FRAME_W-1:0] tx_word,
   output logic               tx_pop,
   input  logic               sclk_i,
   input  logic               ssel_n_i,
   input  logic               mosi_i,
   output logic               miso_o,
   output logic               rx_push,
   output logic [FRAME_W-1:0] rx_word,
   output logic               active
);
   localparam int CW = $clog2(FRAME_W);
   localparam int SW = 3 * SYNC_STAGES;

   logic [SW-1:0]      chain;
   logic [2:0]         pins_s;
   logic               sclk_d, ssel_d;
   logic               sclk_rise, sclk_fall, ssel_fall, ssel_rise;
   logic [FRAME_W-1:0] tx_sh, rx_sh;
   logic [CW-1:0]      bit_cnt;
   logic               in_bit, last_bit;

   // {mosi, ssel_n, sclk} per stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= {SYNC_STAGES{3'b010}};
         sclk_d <= 1'b0;
         ssel_d <= 1'b1;
      end else begin
         chain  <= {chain[SW-4:0], mosi_i, ssel_n_i, sclk_i};
         sclk_d <= pins_s[0];
         ssel_d <= pins_s[1];
      end
   end

   assign pins_s    = chain[SW-1 -: 3];
   assign sclk_rise = pins_s[0] && !sclk_d;
   assign sclk_fall = !pins_s[0] && sclk_d;
   assign ssel_fall = !pins_s[1] && ssel_d;
   assign ssel_rise = pins_s[1] && !ssel_d;

   assign miso_o   = tx_sh[FRAME_W-1];
   assign in_bit   = lb ? tx_sh[FRAME_W-1] : pins_s[2];
   assign last_bit = (bit_cnt == CW'(FRAME_W - 1));
   assign tx_pop   = run && ssel_fall && tx_valid;
   assign rx_push  = run && active && !ssel_fall && !ssel_rise && sclk_rise && last_bit;
   assign rx_word  = {rx_sh[FRAME_W-2:0], in_bit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh   <= '0;
         rx_sh   <= '0;
         bit_cnt <= '0;
         active  <= 1'b0;
      end else if (!run) begin
         bit_cnt <= '0;
         active  <= 1'b0;
      end else if (ssel_fall) begin
         tx_sh   <= tx_valid ? tx_word : '0;
         bit_cnt <= '0;
         active  <= 1'b1;
      end else if (ssel_rise) begin
         active  <= 1'b0;
      end else if (active && sclk_rise) begin
         rx_sh <= rx_word;
         if (last_bit) active  <= 1'b0;
         else          bit_cnt <= bit_cnt + 1'b1;
      end else if (active && sclk_fall) begin
         tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
      end
   end

   assert_one_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> !rx_push);

endmodule

// File: rtl/spi_port_ctl.sv
module spi_port_ctl
   import spi_port_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int FRAME_W     = 8,
   parameter int FIFO_DEPTH  = 8,
   parameter int CLK_HALF    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sclk_o,
   output logic              sclk_oe,
   input  logic              sclk_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              miso_i,
   output logic              ssel_n_o,
   output logic              ssel_oe,
   input  logic              ssel_n_i
);
   generate
      if (FRAME_W < 4 || FRAME_W > 16 || FRAME_W > DATA_W) begin : g_bad_frame
         $error("spi_port_ctl: FRAME_W out of range");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_port_ctl: FIFO_DEPTH must be a power of two >= 2");
      end
      if (CLK_HALF < 1 || SYNC_STAGES < 2) begin : g_bad_timing
         $error("spi_port_ctl: CLK_HALF >= 1 and SYNC_STAGES >= 2 required");
      end
   endgenerate

   ctrl_t              ctrl;
   logic               m_run, s_run;
   logic               wr_ctrl, wr_data, rd_data;
   logic               tx_full, tx_empty, tx_pop, m_pop, s_pop;
   logic               rx_full, rx_empty, rx_push, m_push, s_push;
   logic [FRAME_W-1:0] tx_head, rx_head, rx_in, m_rx, s_rx;
   logic               m_active, s_active, busy;
   logic               unused_wdata;

   assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
   assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
   assign rd_data = reg_rd && (reg_addr == ADDR_DATA);
   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ctrl) begin
         ctrl.sod <= reg_wdata[3];
         ctrl.en  <= reg_wdata[1];
         ctrl.lb  <= reg_wdata[0];
         if (!ctrl.en) ctrl.ms <= reg_wdata[2];
      end
   end

   assign m_run = ctrl.en && !ctrl.ms;
   assign s_run = ctrl.en && ctrl.ms;

   spi_port_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(wr_data), .din(reg_wdata[FRAME_W-1:0]),
      .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty));

   spi_port_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_in),
      .pop(rd_data), .dout(rx_head), .full(rx_full), .empty(rx_empty));

   spi_port_master #(.FRAME_W(FRAME_W), .CLK_HALF(CLK_HALF)) u_mst (
      .clk(clk), .rst_n(rst_n), .run(m_run), .lb(ctrl.lb),
      .tx_valid(!tx_empty), .tx_word(tx_head), .tx_pop(m_pop),
      .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o), .ssel_n_o(ssel_n_o),
      .rx_push(m_push), .rx_word(m_rx), .active(m_active));

   spi_port_slave #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_slv (
      .clk(clk), .rst_n(rst_n), .run(s_run), .lb(ctrl.lb),
      .tx_valid(!tx_empty), .tx_word(tx_head), .tx_pop(s_pop),
      .sclk_i(sclk_i), .ssel_n_i(ssel_n_i), .mosi_i(mosi_i), .miso_o(miso_o),
      .rx_push(s_push), .rx_word(s_rx), .active(s_active));

   assign tx_pop  = m_pop | s_pop;
   assign rx_push = m_push | s_push;
   assign rx_in   = m_push ? m_rx : s_rx;
   assign busy    = m_active || s_active || !tx_empty;

   assign sclk_oe = m_run;
   assign mosi_oe = m_run;
   assign ssel_oe = m_run;
   assign miso_oe = s_run && !ctrl.sod;

   always_comb begin
      case (reg_addr)
         ADDR_CTRL: reg_rdata = DATA_W'(ctrl);
         ADDR_DATA: reg_rdata = rx_empty ? '0 : DATA_W'(rx_head);
         ADDR_STAT: reg_rdata = DATA_W'({busy, !rx_empty, !tx_full});
         default:   reg_rdata = '0;
      endcase
   end

   assert_ms_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && ctrl.en) |=> (ctrl.ms == $past(ctrl.ms)));

   assert_oe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(miso_oe && (mosi_oe || sclk_oe)));

   assert_idle_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.en |=> (ssel_n_o && !sclk_o));

   assert_push_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_push && s_push));

   assert_full_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && wr_data && !tx_pop) |=> tx_full);

endmodule

// File: tb/sim_spi_port_ctl.sv
module sim_spi_port_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam logic [15:0] MASK = 16'((1 << W) - 1);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe, ssel_n_o, ssel_oe;
   logic        sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b1, ssel_n_i = 1'b1;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit live = 1'b0;

   spi_port_ctl #(.DATA_W(16), .FRAME_W(W), .FIFO_DEPTH(8), .CLK_HALF(2), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i),
      .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
      .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i),
      .ssel_n_o(ssel_n_o), .ssel_oe(ssel_oe), .ssel_n_i(ssel_n_i));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog R1..: actual hung expected done");
         finish_run();
      end
   end

   // behavioural control model, compared with the enables on every clock
   bit m_sod = 0, m_ms = 0, m_en = 0, m_lb = 0;
   always @(posedge clk) begin
      if (rst_n && reg_wr && reg_addr == 2'd0) begin
         if (!m_en) m_ms <= reg_wdata[2];
         m_sod <= reg_wdata[3];
         m_en  <= reg_wdata[1];
         m_lb  <= reg_wdata[0];
      end
   end
   always @(negedge clk) begin
      if (live) begin
         chk("R4 per-clock enables", {12'd0, sclk_oe, mosi_oe, ssel_oe, miso_oe},
             {12'd0, m_en && !m_ms, m_en && !m_ms, m_en && !m_ms, m_en && m_ms && !m_sod});
      end
   end

   // bench slave used while the port is master
   logic [15:0] miso_q[$];
   logic [15:0] mosi_seen[$];
   logic [15:0] bsh = 16'd0, cap = 16'd0;
   always @(negedge ssel_n_o) if (live) begin
      bsh = (miso_q.size() > 0) ? miso_q.pop_front() : 16'hFFFF;
      cap = 16'd0;
      miso_i = bsh[W-1];
   end
   always @(negedge sclk_o) if (live && !ssel_n_o) begin
      bsh = bsh << 1;
      miso_i = bsh[W-1];
   end
   always @(posedge sclk_o) if (live && !ssel_n_o) cap = {cap[14:0], mosi_o};
   always @(posedge ssel_n_o) if (live) mosi_seen.push_back(cap & MASK);

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [15:0] s;
      for (int i = 0; i < 5000; i++) begin
         rd(2'd2, s);
         if (!s[2]) break;
      end
   endtask

   // bench master used while the port is slave
   task automatic xfer(input logic [15:0] out_w, output logic [15:0] in_w);
      in_w = 16'd0;
      @(negedge clk); ssel_n_i = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = W - 1; i >= 0; i--) begin
         mosi_i = out_w[i];
         repeat (6) @(negedge clk);
         sclk_i = 1'b1;
         in_w = {in_w[14:0], miso_o};
         repeat (6) @(negedge clk);
         sclk_i = 1'b0;
      end
      repeat (6) @(negedge clk);
      ssel_n_i = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      logic [15:0] d, got;
      logic [15:0] exp_tx[3] = '{16'h0012, 16'h0034, 16'h0056};
      bit quiet;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      live = 1'b1;

      // R1 reset state
      rd(2'd0, d); chk("R1 ctrl after reset", d, 16'h0000);
      rd(2'd2, d); chk("R1 status after reset", d, 16'h0001);
      chk("R1 enables and select after reset",
          {11'd0, sclk_oe, mosi_oe, ssel_oe, miso_oe, ssel_n_o}, 16'h0001);

      // R2 field layout readback
      wr(2'd0, 16'h0009); rd(2'd0, d); chk("R2 ctrl readback", d, 16'h0009);
      wr(2'd0, 16'h0000);

      // R5 disabled port queues but stays quiet; R10 busy from queued words
      miso_q.push_back(16'h00A5); miso_q.push_back(16'h003C); miso_q.push_back(16'h0081);
      foreach (exp_tx[i]) wr(2'd1, exp_tx[i]);
      rd(2'd2, d); chk("R10 busy with queued words while off", d, 16'h0005);
      quiet = 1'b1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (!ssel_n_o || sclk_o) quiet = 1'b0;
      end
      chk("R5 no bus activity while disabled", 16'(quiet), 16'd1);

      // R6 / R12 master frames in order
      wr(2'd0, 16'h0002);
      wait_idle();
      chk("R12 frame count", 16'(mosi_seen.size()), 16'd3);
      foreach (exp_tx[i]) begin
         got = (mosi_seen.size() > 0) ? mosi_seen.pop_front() : 16'hDEAD;
         chk("R6 R12 MOSI word", got, exp_tx[i]);
      end
      rd(2'd1, d); chk("R6 rx word 1", d, 16'h00A5);
      rd(2'd1, d); chk("R6 rx word 2", d, 16'h003C);
      rd(2'd1, d); chk("R6 rx word 3", d, 16'h0081);
      rd(2'd1, d); chk("R9 empty read returns 0", d, 16'h0000);
      rd(2'd2, d); chk("R9 R10 status after drain", d, 16'h0001);

      // R3 role lock
      wr(2'd0, 16'h0006); rd(2'd0, d); chk("R3 role locked while enabled", d, 16'h0002);
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'h0006); rd(2'd0, d); chk("R3 role and enable in one write", d, 16'h0006);
      chk("R4 slave drives MISO", 16'(miso_oe), 16'd1);
      wr(2'd0, 16'h000E); rd(2'd0, d); chk("R3 sod writable while enabled", d, 16'h000E);
      chk("R4 slave output off", 16'(miso_oe), 16'd0);
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'h000A);
      chk("R4 sod ignored as master", {14'd0, mosi_oe, miso_oe}, 16'h0002);

      // R7 master loopback ignores miso_i (bench slave sends all ones)
      wr(2'd0, 16'h0003);
      wr(2'd1, 16'h005A); wait_idle();
      rd(2'd1, d); chk("R7 master loopback word", d, 16'h005A);
      wr(2'd1, 16'h0000); wait_idle();
      rd(2'd1, d); chk("R7 loopback ignores pin", d, 16'h0000);
      wr(2'd1, 16'hABCD); wait_idle();
      rd(2'd1, d); chk("R9 right-justified zero-filled", d, 16'h00CD);

      // R8 full transmit FIFO drops the ninth word
      wr(2'd0, 16'h0000);
      for (int i = 1; i <= 9; i++) wr(2'd1, 16'(i));
      rd(2'd2, d); chk("R8 status with full tx FIFO", d, 16'h0004);
      wr(2'd0, 16'h0003);
      wait_idle();
      for (int i = 1; i <= 8; i++) begin
         rd(2'd1, d); chk("R8 R9 word order after full", d, 16'(i));
      end
      rd(2'd1, d); chk("R8 ninth word dropped", d, 16'h0000);
      mosi_seen.delete();

      // R11 slave frames
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'h0006);
      wr(2'd1, 16'h00C3);
      rd(2'd2, d); chk("R10 busy with word queued in slave", d, 16'h0005);
      xfer(16'h0096, got);
      chk("R11 slave MISO word", got, 16'h00C3);
      rd(2'd1, d); chk("R11 slave rx word", d, 16'h0096);
      xfer(16'h005A, got);
      chk("R11 slave sends zeros when empty", got, 16'h0000);
      rd(2'd1, d); chk("R11 one rx word per frame", d, 16'h005A);
      rd(2'd1, d); chk("R11 no extra rx word", d, 16'h0000);

      // R7 slave loopback
      wr(2'd0, 16'h0007);
      wr(2'd1, 16'h003C);
      xfer(16'h00FF, got);
      chk("R7 slave loopback MISO", got, 16'h003C);
      rd(2'd1, d); chk("R7 slave loopback rx ignores MOSI", d, 16'h003C);
      wr(2'd0, 16'h000F);
      chk("R4 sod blocks MISO in slave", 16'(miso_oe), 16'd0);

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule